// File: doc/BRIEF.md
# Sorted-Store Biased Tournament Selector

This block holds the population of an evolutionary search in a register array split into a better half and a worse half, and chooses parent pairs from it. Each time a pair of freshly evaluated offspring arrives, the two fitness values are compared. The better offspring goes into the next slot of the upper half and the other into the next slot of the lower half. Over time the upper half therefore collects the stronger individuals without any sorting pass.

Parents are chosen by pairwise tournaments on pseudo-random addresses taken from a 16-bit linear feedback shift register. The half-select bit of each address is steered toward the upper half, so stronger individuals are drawn more often. This approximates fitness-proportional selection with no division and no probabilities. Each request draws four addresses, runs two tournaments, and returns two winners (index, genome and fitness) through a valid/ready handshake.

Top module: `sortsel_top`

## Requirements
- R1: After a synchronous active-high reset, req_ready is 1 and out_valid is 0. Every slot holds genome 0 and fitness all-ones, and the generator holds the seed (default 16'hACE1).
- R2: On a cycle with st_valid high, the individual with the lower fitness goes to slot DEPTH/2 + upper pointer and the other to slot lower pointer. On equal fitness, the A input goes to the upper slot. The memory shows the write from the next cycle on.
- R3: Both write pointers are 0 after reset. Each advances by one per store and wraps from DEPTH/2-1 to 0, so the N-th store (counting from 0) uses slots DEPTH/2 + N mod DEPTH/2 and N mod DEPTH/2.
- R4: The generator state s steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It advances exactly four steps on each accepted request, holds otherwise, and is never zero.
- R5: The four draws of a request are s, next(s), next^2(s) and next^3(s), where s is the state when the request is accepted. A draw d maps to address {d[15] | d[14], d[AW-2:0]}, with AW = log2(DEPTH) and MSB 1 meaning the upper half. This gives the upper half a 3/4 share.
- R6: Draws 0 and 1 compete for output A, and draws 2 and 3 compete for output B. The lower fitness wins and a tie goes to the earlier draw. Each output carries the winning slot index, genome and fitness.
- R7: A request is accepted when req_valid and req_ready are both high. req_ready then stays low and out_valid rises two clock edges after acceptance. The outputs hold stable while out_valid is high and out_ready is low. The edge where out_valid and out_ready are both high ends the result, and req_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store the offspring pair this cycle |
| st_gene_a | input | GENE_W | Genome of offspring A |
| st_fit_a | input | FIT_W | Objective value of A (lower is better) |
| st_gene_b | input | GENE_W | Genome of offspring B |
| st_fit_b | input | FIT_W | Objective value of B |
| req_valid | input | 1 | Selection request |
| req_ready | output | 1 | Selector can accept a request |
| out_valid | output | 1 | Winner pair is available |
| out_ready | input | 1 | Consumer takes the winner pair |
| win_idx_a | output | AW | Slot index of winner A |
| win_gene_a | output | GENE_W | Genome of winner A |
| win_fit_a | output | FIT_W | Fitness of winner A |
| win_idx_b | output | AW | Slot index of winner B |
| win_gene_b | output | GENE_W | Genome of winner B |
| win_fit_b | output | FIT_W | Fitness of winner B |

## Verification
A wrong generator state or step count shifts every later draw, so the winner index of the next request already differs from the independent model. A write pointer or half-order fault leaves a wrong genome or fitness in a slot. That fault appears at the ports as soon as a tournament draws that slot, which the long run of requests over a filled memory makes likely within a few dozen requests. Handshake faults show in the same cycle as a changed output or ready level.

// File: rtl/sortsel_pkg.sv
package sortsel_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] SEED_DEF  = 16'hACE1;
    localparam int          DRAWS     = 4;
    localparam int          BIAS_HI   = 15;
    localparam int          BIAS_LO   = 14;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_DRAWN = 2'd1,
        SEL_HOLD  = 2'd2
    } sel_phase_e;

    // one step of the 16-bit Fibonacci register, taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s,
                                                   input int n);
        logic [LFSR_W-1:0] t;
        t = s;
        for (int i = 0; i < n; i++) t = lfsr_next(t);
        return t;
    endfunction

endpackage

// File: rtl/sortsel_lfsr.sv
module sortsel_lfsr
    import sortsel_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = SEED_DEF
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            adv,
    output logic [DRAWS-1:0][LFSR_W-1:0]    draws
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)      state_q <= SEED;
        else if (adv) state_q <= lfsr_adv(state_q, DRAWS);
    end

    for (genvar k = 0; k < DRAWS; k++) begin : g_draw
        assign draws[k] = lfsr_adv(state_q, k);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);                                             // R4
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> state_q == $past(state_q));                        // R4

endmodule

// File: rtl/sortsel_store.sv
module sortsel_store
    import sortsel_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int GENE_W = 32,
    parameter int FIT_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW - 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [GENE_W-1:0]            gene_a,
    input  logic [FIT_W-1:0]             fit_a,
    input  logic [GENE_W-1:0]            gene_b,
    input  logic [FIT_W-1:0]             fit_b,
    input  logic [DRAWS-1:0][AW-1:0]     rd_addr,
    output logic [DRAWS-1:0][GENE_W-1:0] rd_gene,
    output logic [DRAWS-1:0][FIT_W-1:0]  rd_fit
);

    logic [GENE_W-1:0] gene_mem [DEPTH];
    logic [FIT_W-1:0]  fit_mem  [DEPTH];
    logic [PW-1:0]     hi_ptr_q, lo_ptr_q;

    logic              a_wins;
    logic [AW-1:0]     hi_slot, lo_slot;
    logic [GENE_W-1:0] good_gene, poor_gene;
    logic [FIT_W-1:0]  good_fit, poor_fit;

    always_comb begin
        a_wins    = (fit_a <= fit_b);
        hi_slot   = {1'b1, hi_ptr_q};
        lo_slot   = {1'b0, lo_ptr_q};
        good_gene = a_wins ? gene_a : gene_b;
        good_fit  = a_wins ? fit_a  : fit_b;
        poor_gene = a_wins ? gene_b : gene_a;
        poor_fit  = a_wins ? fit_b  : fit_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_ptr_q <= '0;
            lo_ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                gene_mem[i] <= '0;
                fit_mem[i]  <= '1;
            end
        end else if (wr_en) begin
            gene_mem[hi_slot] <= good_gene;
            fit_mem[hi_slot]  <= good_fit;
            gene_mem[lo_slot] <= poor_gene;
            fit_mem[lo_slot]  <= poor_fit;
            hi_ptr_q <= hi_ptr_q + 1'b1;
            lo_ptr_q <= lo_ptr_q + 1'b1;
        end
    end

    for (genvar k = 0; k < DRAWS; k++) begin : g_rd
        assign rd_gene[k] = gene_mem[rd_addr[k]];
        assign rd_fit[k]  = fit_mem[rd_addr[k]];
    end

    AST_PTRS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        hi_ptr_q == lo_ptr_q);                                      // R3
    AST_SORTED_PAIR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> fit_mem[$past(hi_slot)] <= fit_mem[$past(lo_slot)]); // R2

endmodule

// File: rtl/sortsel_tourney.sv
module sortsel_tourney
    import sortsel_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int GENE_W = 32,
    parameter int FIT_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int NWIN  = DRAWS / 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic                         adv,
    input  logic [DRAWS-1:0][LFSR_W-1:0] draws,
    output logic [DRAWS-1:0][AW-1:0]     rd_addr,
    input  logic [DRAWS-1:0][GENE_W-1:0] rd_gene,
    input  logic [DRAWS-1:0][FIT_W-1:0]  rd_fit,
    output logic [NWIN-1:0][AW-1:0]      win_idx,
    output logic [NWIN-1:0][GENE_W-1:0]  win_gene,
    output logic [NWIN-1:0][FIT_W-1:0]   win_fit
);

    // half select forced high when either bias bit is set
    function automatic logic [AW-1:0] draw_addr(input logic [LFSR_W-1:0] d);
        return {d[BIAS_HI] | d[BIAS_LO], d[AW-2:0]};
    endfunction

    sel_phase_e                  phase_q;
    logic [DRAWS-1:0][AW-1:0]    addr_q, addr_now;
    logic [NWIN-1:0][AW-1:0]     idx_d,  idx_q;
    logic [NWIN-1:0][GENE_W-1:0] gene_d, gene_q;
    logic [NWIN-1:0][FIT_W-1:0]  fit_d,  fit_q;

    assign req_ready = (phase_q == SEL_IDLE);
    assign out_valid = (phase_q == SEL_HOLD);
    assign adv       = req_ready && req_valid;
    assign rd_addr   = addr_q;

    for (genvar k = 0; k < DRAWS; k++) begin : g_addr
        assign addr_now[k] = draw_addr(draws[k]);
    end

    for (genvar p = 0; p < NWIN; p++) begin : g_match
        logic first_wins;
        assign first_wins = rd_fit[2*p] <= rd_fit[2*p+1];
        assign idx_d[p]   = first_wins ? addr_q[2*p]  : addr_q[2*p+1];
        assign gene_d[p]  = first_wins ? rd_gene[2*p] : rd_gene[2*p+1];
        assign fit_d[p]   = first_wins ? rd_fit[2*p]  : rd_fit[2*p+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SEL_IDLE;
            addr_q  <= '0;
            idx_q   <= '0;
            gene_q  <= '0;
            fit_q   <= '0;
        end else begin
            case (phase_q)
                SEL_IDLE: if (req_valid) begin
                    addr_q  <= addr_now;
                    phase_q <= SEL_DRAWN;
                end
                SEL_DRAWN: begin
                    idx_q   <= idx_d;
                    gene_q  <= gene_d;
                    fit_q   <= fit_d;
                    phase_q <= SEL_HOLD;
                end
                SEL_HOLD: if (out_ready) phase_q <= SEL_IDLE;
                default: phase_q <= SEL_IDLE;
            endcase
        end
    end

    assign win_idx  = idx_q;
    assign win_gene = gene_q;
    assign win_fit  = fit_q;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        adv |=> !req_ready && !out_valid);                          // R7
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(idx_q) && $stable(fit_q)); // R7
    AST_WIN_A_BEST: assert property (@(posedge clk) disable iff (rst)
        phase_q == SEL_DRAWN |=> fit_q[0] <= $past(rd_fit[0]) && fit_q[0] <= $past(rd_fit[1])); // R6
    AST_WIN_B_BEST: assert property (@(posedge clk) disable iff (rst)
        phase_q == SEL_DRAWN |=> fit_q[1] <= $past(rd_fit[2]) && fit_q[1] <= $past(rd_fit[3])); // R6

endmodule

// File: rtl/sortsel_top.sv
module sortsel_top
    import sortsel_pkg::*;
#(
    parameter int                DEPTH  = 16,
    parameter int                GENE_W = 32,
    parameter int                FIT_W  = 16,
    parameter logic [LFSR_W-1:0] SEED   = SEED_DEF,
    localparam int               AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [GENE_W-1:0] st_gene_a,
    input  logic [FIT_W-1:0]  st_fit_a,
    input  logic [GENE_W-1:0] st_gene_b,
    input  logic [FIT_W-1:0]  st_fit_b,
    input  logic              req_valid,
    output logic              req_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [AW-1:0]     win_idx_a,
    output logic [GENE_W-1:0] win_gene_a,
    output logic [FIT_W-1:0]  win_fit_a,
    output logic [AW-1:0]     win_idx_b,
    output logic [GENE_W-1:0] win_gene_b,
    output logic [FIT_W-1:0]  win_fit_b
);

    localparam int NWIN = DRAWS / 2;

    logic                         adv;
    logic [DRAWS-1:0][LFSR_W-1:0] draws;
    logic [DRAWS-1:0][AW-1:0]     rd_addr;
    logic [DRAWS-1:0][GENE_W-1:0] rd_gene;
    logic [DRAWS-1:0][FIT_W-1:0]  rd_fit;
    logic [NWIN-1:0][AW-1:0]      win_idx;
    logic [NWIN-1:0][GENE_W-1:0]  win_gene;
    logic [NWIN-1:0][FIT_W-1:0]   win_fit;

    sortsel_lfsr #(.SEED(SEED)) lfsr_i (
        .clk(clk), .rst(rst), .adv(adv), .draws(draws)
    );

    sortsel_store #(.DEPTH(DEPTH), .GENE_W(GENE_W), .FIT_W(FIT_W)) store_i (
        .clk(clk), .rst(rst), .wr_en(st_valid),
        .gene_a(st_gene_a), .fit_a(st_fit_a),
        .gene_b(st_gene_b), .fit_b(st_fit_b),
        .rd_addr(rd_addr), .rd_gene(rd_gene), .rd_fit(rd_fit)
    );

    sortsel_tourney #(.DEPTH(DEPTH), .GENE_W(GENE_W), .FIT_W(FIT_W)) tourney_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .adv(adv), .draws(draws),
        .rd_addr(rd_addr), .rd_gene(rd_gene), .rd_fit(rd_fit),
        .win_idx(win_idx), .win_gene(win_gene), .win_fit(win_fit)
    );

    assign win_idx_a  = win_idx[0];
    assign win_gene_a = win_gene[0];
    assign win_fit_a  = win_fit[0];
    assign win_idx_b  = win_idx[1];
    assign win_gene_b = win_gene[1];
    assign win_fit_b  = win_fit[1];

endmodule

// File: tb/sortsel_top_tb_top.sv
module sortsel_top_tb_top;

    localparam int DEPTH  = 16;
    localparam int HALF   = DEPTH / 2;
    localparam int AW     = 4;
    localparam int GENE_W = 32;
    localparam int FIT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              st_valid = 1'b0;
    logic [GENE_W-1:0] st_gene_a = '0, st_gene_b = '0;
    logic [FIT_W-1:0]  st_fit_a = '0, st_fit_b = '0;
    logic              req_valid = 1'b0, out_ready = 1'b0;
    logic              req_ready, out_valid;
    logic [AW-1:0]     win_idx_a, win_idx_b;
    logic [GENE_W-1:0] win_gene_a, win_gene_b;
    logic [FIT_W-1:0]  win_fit_a, win_fit_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the population and the generator
    logic [GENE_W-1:0] m_gene [DEPTH];
    logic [FIT_W-1:0]  m_fit  [DEPTH];
    int                m_ptr;
    logic [15:0]       m_lfsr;
    int                upper_wins, lower_wins;

    always #10 clk = ~clk;

    sortsel_top #(.DEPTH(DEPTH), .GENE_W(GENE_W), .FIT_W(FIT_W)) dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid),
        .st_gene_a(st_gene_a), .st_fit_a(st_fit_a),
        .st_gene_b(st_gene_b), .st_fit_b(st_fit_b),
        .req_valid(req_valid), .req_ready(req_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .win_idx_a(win_idx_a), .win_gene_a(win_gene_a), .win_fit_a(win_fit_a),
        .win_idx_b(win_idx_b), .win_gene_b(win_gene_b), .win_fit_b(win_fit_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] m_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int m_addr(input logic [15:0] d);
        return ((d[15] | d[14]) ? HALF : 0) + int'(d[2:0]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_gene[i] = '0;
            m_fit[i]  = '1;
        end
        m_ptr  = 0;
        m_lfsr = 16'hACE1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_store(input logic [GENE_W-1:0] ga, input logic [FIT_W-1:0] fa,
                            input logic [GENE_W-1:0] gb, input logic [FIT_W-1:0] fb);
        @(negedge clk);
        st_valid = 1'b1;
        st_gene_a = ga; st_fit_a = fa; st_gene_b = gb; st_fit_b = fb;
        @(negedge clk);
        st_valid = 1'b0;
        if (fa <= fb) begin
            m_gene[HALF + m_ptr] = ga; m_fit[HALF + m_ptr] = fa;
            m_gene[m_ptr] = gb;        m_fit[m_ptr] = fb;
        end else begin
            m_gene[HALF + m_ptr] = gb; m_fit[HALF + m_ptr] = fb;
            m_gene[m_ptr] = ga;        m_fit[m_ptr] = fa;
        end
        m_ptr = (m_ptr + 1) % HALF;
    endtask

    // one request, compared against the model; tag names the scenario requirement
    task automatic run_select(input string tag, input bit hold_check);
        logic [15:0] d [4];
        int          a [4];
        int          wi [2];
        d[0] = m_lfsr;
        for (int k = 1; k < 4; k++) d[k] = m_step(d[k-1]);
        for (int k = 0; k < 4; k++) a[k] = m_addr(d[k]);
        m_lfsr = m_step(d[3]);
        for (int p = 0; p < 2; p++)
            wi[p] = (m_fit[a[2*p]] <= m_fit[a[2*p+1]]) ? a[2*p] : a[2*p+1];
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (hold_check) begin
            chk(req_ready == 1'b0, "R7", "req_ready after accept", req_ready, 0);
            chk(out_valid == 1'b0, "R7", "out_valid one edge after accept", out_valid, 0);
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", "out_valid two edges after accept", out_valid, 1);
        chk(int'(win_idx_a) == wi[0], {tag, "/R5/R6"}, "win_idx_a", win_idx_a, wi[0]);
        chk(int'(win_idx_b) == wi[1], {tag, "/R5/R6"}, "win_idx_b", win_idx_b, wi[1]);
        chk(win_fit_a == m_fit[wi[0]], {tag, "/R6"}, "win_fit_a", win_fit_a, m_fit[wi[0]]);
        chk(win_fit_b == m_fit[wi[1]], {tag, "/R6"}, "win_fit_b", win_fit_b, m_fit[wi[1]]);
        chk(win_gene_a == m_gene[wi[0]], {tag, "/R6"}, "win_gene_a", win_gene_a, m_gene[wi[0]]);
        chk(win_gene_b == m_gene[wi[1]], {tag, "/R6"}, "win_gene_b", win_gene_b, m_gene[wi[1]]);
        for (int p = 0; p < 2; p++)
            if (wi[p] >= HALF) upper_wins++; else lower_wins++;
        if (hold_check) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R7", "out_valid held without out_ready", out_valid, 1);
            chk(int'(win_idx_a) == wi[0], "R7", "win_idx_a held", win_idx_a, wi[0]);
            chk(req_ready == 1'b0, "R7", "req_ready while holding", req_ready, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        if (hold_check) begin
            chk(out_valid == 1'b0, "R7", "out_valid after take", out_valid, 0);
            chk(req_ready == 1'b1, "R7", "req_ready after take", req_ready, 1);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(req_ready == 1'b1, "R1", "req_ready at reset", req_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
        // empty population: every slot reads as genome 0, fitness all-ones
        run_select("R1", 1'b1);
        run_select("R1", 1'b0);
    endtask

    task automatic t_store_order();
        do_reset();
        do_store(32'hA000_0001, 16'd50, 32'hB000_0001, 16'd90);
        do_store(32'hA000_0002, 16'd300, 32'hB000_0002, 16'd20);
        do_store(32'hA000_0003, 16'd77, 32'hB000_0003, 16'd77); // tie keeps A on top
        for (int i = 3; i < HALF; i++)
            do_store(32'hC000_0000 + i, 16'(i * 37 % 200), 32'hD000_0000 + i, 16'(i * 53 % 200));
        for (int r = 0; r < 40; r++) run_select("R2", 1'b0);
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < HALF + 3; i++)
            do_store(32'hE000_0000 + i, 16'(1000 - i * 11), 32'hF000_0000 + i, 16'(400 + i * 29));
        for (int r = 0; r < 40; r++) run_select("R3", 1'b0);
    endtask

    task automatic t_lfsr_hold();
        // idle cycles and stores between requests must not move the generator
        do_reset();
        run_select("R4", 1'b0);
        repeat (7) @(negedge clk);
        do_store(32'h1234_5678, 16'd5, 32'h8765_4321, 16'd6);
        repeat (3) @(negedge clk);
        run_select("R4", 1'b0);
        run_select("R4", 1'b1);
    endtask

    task automatic t_bias();
        do_reset();
        upper_wins = 0;
        lower_wins = 0;
        for (int i = 0; i < HALF; i++)
            do_store(32'h5000_0000 + i, 16'(100 + i * 3), 32'h6000_0000 + i, 16'(600 + i * 7));
        for (int r = 0; r < 200; r++) run_select("R5", 1'b0);
        chk(upper_wins > lower_wins * 2, "R5", "upper-half winners exceed twice lower",
            upper_wins, lower_wins * 2);
    endtask

    initial begin
        t_reset();
        t_store_order();
        t_wrap();
        t_lfsr_hold();
        t_bias();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule